// File: doc/BRIEF.md
# NAND ECC Status Scanner

After a full-page read with hardware error correction, the correction engine leaves one small status code for each 512-byte sector. The codes are packed into 32-bit words held in a small register bank. This block walks the sectors that belong to one page buffer and decodes the error count of each sector. It sums the corrected bit errors, keeps the largest count seen in any one sector, and flags the page when any sector could not be corrected.

The correction engine fills the status bank through a simple write port. A single-cycle `start` pulse then launches a scan, with the buffer number and the number of correction steps per page given at the same edge. The scan handles one sector per clock cycle. When the last sector has been decoded, the block raises `done` for one cycle. The three results stay stable from then until the next accepted start.

The control state machine has four states:
- IDLE waits for `start`. When `start` arrives it takes the range (accept) and moves to FETCH.
- FETCH loads the first status word and always moves to SCAN.
- SCAN decodes one sector per cycle. It stays in SCAN until the last sector, then moves to DONE.
- DONE drives `done` and always returns to IDLE.

Top module: `ecc_stat_scan`

## Requirements
- R1: For an accepted start, the sectors scanned are the effective step count E consecutive indices beginning at `buf_num`×E. The last index is `buf_num`×E+E−1. All sector arithmetic is modulo 64, so a range that runs past sector 63 continues at sector 0.
- R2: A `steps` value of 0 is treated as 1, and any value above 16 is treated as 16. This gives the effective step count E.
- R3: Sector i is read from status word i/4. Its count is the low 4 bits of the byte at bit offset (3 − i mod 4)×8, so sector 0 of a word sits in bits 27:24. The upper 4 bits of every byte are ignored. Ranges that start or cross inside a word are decoded correctly.
- R4: A sector count of 15 sets `uncorr`. That count is added neither to `corr_total` nor to `max_flips`. `uncorr` then stays set until the next accepted start.
- R5: `corr_total` equals the sum of all counts from 0 to 14 among the scanned sectors.
- R6: `max_flips` equals the largest count from 0 to 14 among the scanned sectors, or 0 if there is none.
- R7: An accepted start clears `corr_total`, `max_flips` and `uncorr` to zero. Outside a scan, all three hold their values.
- R8: `done` is high for exactly one cycle. When the start is sampled at clock edge 0, `done` is high in the cycle that follows edge E+1.
- R9: A `start` pulse that arrives while a scan is in progress (FETCH or SCAN) is ignored. It changes neither the range, the results nor the timing, and it produces no extra `done`.
- R10: When `stat_we` is high at a clock edge, `stat_wdata` is written to status word `stat_waddr`. Later scans use the new contents.
- R11: After reset, `done` and `uncorr` are low, `corr_total` and `max_flips` are zero, and every status word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_we | input | 1 | Status word write enable |
| stat_waddr | input | 4 | Status word index to write |
| stat_wdata | input | 32 | Packed status word, four sectors |
| start | input | 1 | Single-cycle scan request |
| buf_num | input | 4 | Page buffer number |
| steps | input | 5 | Correction steps per page (1 to 16) |
| done | output | 1 | One-cycle scan completion pulse |
| corr_total | output | 8 | Sum of correctable sector counts |
| max_flips | output | 4 | Largest correctable sector count |
| uncorr | output | 1 | At least one sector had count 15 |

## Verification
The bench aims at these corner cases, each with the fault it would expose:
- **Ranges that begin in the middle of a word and cross into the next word.** A design that fetched the next word at the wrong index would decode stale lanes.
- **Ranges that wrap past sector 63.** A design without modulo arithmetic would read past the bank instead of returning to word 0.
- **Byte lanes whose upper nibbles are all ones.** A design that masked the wrong bits, or read the lanes in reversed order, would report wrong counts or false uncorrectable flags.
- **Sectors with code 15.** A design that added code 15 into the sum or the maximum would inflate both results.
- **A clean scan right after a failing one.** A design that did not clear its results would carry `uncorr` across the two scans.
- **A start pulse injected mid-scan.** A design that accepted it would restart with a new range and report late or twice.
- **Step counts 0, 1, 16 and 31.** These test the clamping rule and the latency at both ends of the range.

// File: rtl/ecc_scan_pkg.sv
package ecc_scan_pkg;

    // Control states of the sector walker.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SCAN  = 2'd2,
        ST_DONE  = 2'd3
    } scan_state_t;

    // Packing of a status word: four sectors, one byte each.
    localparam int LANES     = 4;
    localparam int LANE_BITS = 8;

endpackage

// File: rtl/ecc_stat_bank.sv
// Register bank holding packed per-sector status words.
module ecc_stat_bank #(
    parameter  int WORDS  = 16,
    parameter  int WORD_W = 32,
    localparam int AW     = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] word_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[w] <= '0;
            end else if (we && (waddr == AW'(w))) begin
                word_q[w] <= wdata;
            end
        end
    end

    assign rdata = word_q[raddr];

endmodule

// File: rtl/ecc_sector_walker.sv
// Control FSM: computes the sector range and steps through it one per cycle.
module ecc_sector_walker
    import ecc_scan_pkg::*;
#(
    parameter  int SECT_W    = 6,
    parameter  int LANE_W    = 2,
    parameter  int BUF_W     = 4,
    parameter  int STEP_W    = 5,
    parameter  int MAX_STEPS = 16,
    localparam int AW        = SECT_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BUF_W-1:0]  buf_num,
    input  logic [STEP_W-1:0] steps,
    output logic [SECT_W-1:0] sec_idx,
    output logic [SECT_W-1:0] last_idx,
    output logic              accept,
    output logic              load_en,
    output logic [AW-1:0]     fetch_addr,
    output logic              sect_valid,
    output logic              done,
    output logic              busy
);

    scan_state_t state_q, state_d;
    logic [SECT_W-1:0] idx_q, last_q;
    logic [STEP_W-1:0] eff_steps;
    logic [SECT_W-1:0] first_calc, last_calc, next_idx;
    logic              at_last;

    // Clamp the step count into the supported range.
    always_comb begin
        if (steps == '0) begin
            eff_steps = STEP_W'(1);
        end else if (steps > STEP_W'(MAX_STEPS)) begin
            eff_steps = STEP_W'(MAX_STEPS);
        end else begin
            eff_steps = steps;
        end
    end

    // Range computation, modulo the sector space.
    assign first_calc = SECT_W'(buf_num) * SECT_W'(eff_steps);
    assign last_calc  = first_calc + SECT_W'(eff_steps) - SECT_W'(1);
    assign next_idx   = idx_q + SECT_W'(1);
    assign at_last    = (idx_q == last_q);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_SCAN;
            ST_SCAN:  if (at_last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sector index and range registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            last_q <= '0;
        end else if (accept) begin
            idx_q  <= first_calc;
            last_q <= last_calc;
        end else if ((state_q == ST_SCAN) && !at_last) begin
            idx_q  <= next_idx;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        accept     = 1'b0;
        load_en    = 1'b0;
        sect_valid = 1'b0;
        done       = 1'b0;
        busy       = 1'b0;
        fetch_addr = idx_q[SECT_W-1:LANE_W];
        unique case (state_q)
            ST_IDLE: begin
                accept = start;
            end
            ST_FETCH: begin
                busy    = 1'b1;
                load_en = 1'b1;
            end
            ST_SCAN: begin
                busy       = 1'b1;
                sect_valid = 1'b1;
                fetch_addr = next_idx[SECT_W-1:LANE_W];
                load_en    = !at_last && (next_idx[LANE_W-1:0] == '0);
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: begin
                accept = 1'b0;
            end
        endcase
    end

    assign sec_idx  = idx_q;
    assign last_idx = last_q;

endmodule

// File: rtl/ecc_lane_decode.sv
// Holds the current status word and extracts the count for one sector lane.
module ecc_lane_decode #(
    parameter  int LANES     = 4,
    parameter  int LANE_BITS = 8,
    parameter  int CNT_W     = 4,
    localparam int LANE_W    = $clog2(LANES),
    localparam int WORD_W    = LANES * LANE_BITS,
    localparam int HI_W      = LANE_BITS - CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] word_in,
    input  logic [LANE_W-1:0] lane,
    output logic [CNT_W-1:0]  count
);

    logic [WORD_W-1:0]     word_q;
    logic [CNT_W-1:0]      cnt_lane [LANES];
    logic [LANES*HI_W-1:0] unused_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_en) begin
            word_q <= word_in;
        end
    end

    // Lane 0 is the most significant byte of the word.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int BASE = (LANES - 1 - l) * LANE_BITS;
        assign cnt_lane[l] = word_q[BASE +: CNT_W];
        assign unused_hi[l*HI_W +: HI_W] = word_q[BASE + CNT_W +: HI_W];
    end

    assign count = cnt_lane[lane];

endmodule

// File: rtl/ecc_err_accum.sv
// Sum, maximum and uncorrectable flag over decoded sector counts.
module ecc_err_accum #(
    parameter int CNT_W = 4,
    parameter int TOT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             valid,
    input  logic [CNT_W-1:0] count,
    output logic [TOT_W-1:0] total,
    output logic [CNT_W-1:0] max_cnt,
    output logic             uncorr
);

    localparam logic [CNT_W-1:0] UNC_CODE = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total   <= '0;
            max_cnt <= '0;
            uncorr  <= 1'b0;
        end else if (clr) begin
            total   <= '0;
            max_cnt <= '0;
            uncorr  <= 1'b0;
        end else if (valid) begin
            if (count == UNC_CODE) begin
                uncorr <= 1'b1;
            end else begin
                total <= total + TOT_W'(count);
                if (count > max_cnt) begin
                    max_cnt <= count;
                end
            end
        end
    end

endmodule

// File: rtl/ecc_stat_scan.sv
// Top: per-sector ECC status scanner.
module ecc_stat_scan
    import ecc_scan_pkg::*;
#(
    parameter  int WORDS     = 16,
    parameter  int CNT_W     = 4,
    parameter  int BUF_W     = 4,
    parameter  int STEP_W    = 5,
    parameter  int MAX_STEPS = 16,
    localparam int AW        = $clog2(WORDS),
    localparam int WORD_W    = LANES * LANE_BITS,
    localparam int LANE_W    = $clog2(LANES),
    localparam int SECT_W    = AW + LANE_W,
    localparam int TOT_W     = $clog2(MAX_STEPS * ((1 << CNT_W) - 2) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_we,
    input  logic [AW-1:0]     stat_waddr,
    input  logic [WORD_W-1:0] stat_wdata,
    input  logic              start,
    input  logic [BUF_W-1:0]  buf_num,
    input  logic [STEP_W-1:0] steps,
    output logic              done,
    output logic [TOT_W-1:0]  corr_total,
    output logic [CNT_W-1:0]  max_flips,
    output logic              uncorr
);

    logic [SECT_W-1:0] sec_idx, last_idx;
    logic              scan_accept, load_en, sect_valid, scan_busy;
    logic [AW-1:0]     fetch_addr;
    logic [WORD_W-1:0] bank_rdata;
    logic [CNT_W-1:0]  sect_count;

    ecc_stat_bank #(
        .WORDS  (WORDS),
        .WORD_W (WORD_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (stat_we),
        .waddr  (stat_waddr),
        .wdata  (stat_wdata),
        .raddr  (fetch_addr),
        .rdata  (bank_rdata)
    );

    ecc_sector_walker #(
        .SECT_W    (SECT_W),
        .LANE_W    (LANE_W),
        .BUF_W     (BUF_W),
        .STEP_W    (STEP_W),
        .MAX_STEPS (MAX_STEPS)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .buf_num    (buf_num),
        .steps      (steps),
        .sec_idx    (sec_idx),
        .last_idx   (last_idx),
        .accept     (scan_accept),
        .load_en    (load_en),
        .fetch_addr (fetch_addr),
        .sect_valid (sect_valid),
        .done       (done),
        .busy       (scan_busy)
    );

    ecc_lane_decode #(
        .LANES     (LANES),
        .LANE_BITS (LANE_BITS),
        .CNT_W     (CNT_W)
    ) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .word_in (bank_rdata),
        .lane    (sec_idx[LANE_W-1:0]),
        .count   (sect_count)
    );

    ecc_err_accum #(
        .CNT_W (CNT_W),
        .TOT_W (TOT_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (scan_accept),
        .valid   (sect_valid),
        .count   (sect_count),
        .total   (corr_total),
        .max_cnt (max_flips),
        .uncorr  (uncorr)
    );

endmodule

// File: rtl/ecc_stat_scan_chk.sv
// Property checker bound to the scanner top.
module ecc_stat_scan_chk #(
    parameter int TOT_W  = 8,
    parameter int CNT_W  = 4,
    parameter int SECT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              busy,
    input logic              clr,
    input logic [SECT_W-1:0] last_idx,
    input logic [TOT_W-1:0]  corr_total,
    input logic [CNT_W-1:0]  max_flips,
    input logic              uncorr
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_RANGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(last_idx))); // R9

    AST_MAX_NOT_UNC: assert property (@(posedge clk) disable iff (!rst_n)
        max_flips != {CNT_W{1'b1}}); // R4

    AST_UNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uncorr && !clr) |=> uncorr); // R4

    AST_MAX_WITHIN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        TOT_W'(max_flips) <= corr_total); // R6

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (corr_total == '0 && max_flips == '0 && !uncorr)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clr) |=> ($stable(corr_total) && $stable(max_flips) && $stable(uncorr))); // R7

endmodule

bind ecc_stat_scan ecc_stat_scan_chk #(
    .TOT_W  (TOT_W),
    .CNT_W  (CNT_W),
    .SECT_W (SECT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .busy       (scan_busy),
    .clr        (scan_accept),
    .last_idx   (last_idx),
    .corr_total (corr_total),
    .max_flips  (max_flips),
    .uncorr     (uncorr)
);

// File: tb/ecc_stat_scan_tb.sv
`timescale 1ns/1ps
module ecc_stat_scan_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stat_we = 1'b0;
    logic [3:0]  stat_waddr = '0;
    logic [31:0] stat_wdata = '0;
    logic        start = 1'b0;
    logic [3:0]  buf_num = '0;
    logic [4:0]  steps = '0;
    logic        done;
    logic [7:0]  corr_total;
    logic [3:0]  max_flips;
    logic        uncorr;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [31:0] mirror [16];

    always #2 clk = ~clk;

    ecc_stat_scan u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_we    (stat_we),
        .stat_waddr (stat_waddr),
        .stat_wdata (stat_wdata),
        .start      (start),
        .buf_num    (buf_num),
        .steps      (steps),
        .done       (done),
        .corr_total (corr_total),
        .max_flips  (max_flips),
        .uncorr     (uncorr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] data);
        @(negedge clk);
        stat_we = 1'b1; stat_waddr = idx[3:0]; stat_wdata = data;
        @(negedge clk);
        stat_we = 1'b0;
        mirror[idx] = data;
    endtask

    function automatic int eff_of(input int st);
        if (st == 0) return 1;
        if (st > 16) return 16;
        return st;
    endfunction

    task automatic model(input int b, input int st, output int et, output int em, output bit eu);
        int e, first, i, nib;
        e = eff_of(st);
        first = (b * e) % 64;
        et = 0; em = 0; eu = 1'b0;
        for (int s = 0; s < e; s++) begin
            i = (first + s) % 64;
            nib = int'((mirror[i / 4] >> ((3 - (i % 4)) * 8)) & 32'hF);
            if (nib == 15) eu = 1'b1;
            else begin
                et += nib;
                if (nib > em) em = nib;
            end
        end
    endtask

    task automatic scan(input int b, input int st, input bit inject, input string tag);
        int et, em, lat;
        bit eu;
        model(b, st, et, em, eu);
        @(negedge clk);
        buf_num = b[3:0]; steps = st[4:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0; buf_num = '0; steps = '0;
        chk(done == 1'b0, {tag, " R8 no early done"}, done, 0);
        lat = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (inject) begin
                start = (k == 3);
                buf_num = 4'd3; steps = 5'd16;
            end
            if (done) begin
                lat = k;
                break;
            end
        end
        start = 1'b0;
        chk(lat == eff_of(st) + 1, {tag, " R8 latency"}, lat, eff_of(st) + 1);
        chk(corr_total == et, {tag, " R5 total"}, corr_total, et);
        chk(max_flips == em, {tag, " R6 max"}, max_flips, em);
        chk(uncorr == eu, {tag, " R4 uncorr"}, uncorr, eu);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R8 single-cycle done"}, done, 0);
        chk(corr_total == et && max_flips == em, {tag, " R7 hold"}, corr_total, et);
        if (inject) begin
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (done) chk(1'b0, {tag, " R9 extra done"}, 1, 0);
            end
            chk(corr_total == et, {tag, " R9 results unchanged"}, corr_total, et);
        end
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R11 done", done, 0);
        chk(corr_total == 0, "R11 total", corr_total, 0);
        chk(max_flips == 0, "R11 max", max_flips, 0);
        chk(uncorr == 1'b0, "R11 uncorr", uncorr, 0);
    endtask

    task automatic t_fill;
        logic [31:0] w;
        for (int k = 0; k < 16; k++) begin
            for (int j = 0; j < 4; j++) begin
                w[(3 - j) * 8 +: 8] = {4'((k * 3 + j) & 15), 4'((k * 5 + j * 7) % 15)};
            end
            wr(k, w);
        end
    endtask

    task automatic t_empty_bank;
        // R11: status words are zero after reset
        scan(0, 16, 1'b0, "R11 zero bank");
        chk(corr_total == 0, "R11 zero bank total", corr_total, 0);
    endtask

    task automatic t_lanes;
        wr(2, 32'hF3_A0_5E_71);   // counts 3,0,14,1 with junk upper nibbles
        scan(2, 4, 1'b0, "R3 junk upper nibbles");
        chk(corr_total == 18 && max_flips == 14 && !uncorr, "R3 lane order", corr_total, 18);
    endtask

    task automatic t_uncorr;
        wr(3, 32'h0F_04_0F_02);   // counts 15,4,15,2
        scan(3, 4, 1'b0, "R4 code 15");
        chk(uncorr == 1'b1 && corr_total == 6 && max_flips == 4, "R4 excluded", corr_total, 6);
        scan(2, 4, 1'b0, "R7 clean after fail");
        chk(uncorr == 1'b0, "R7 uncorr cleared", uncorr, 0);
    endtask

    task automatic t_write;
        wr(0, 32'h01_02_03_04);
        scan(0, 4, 1'b0, "R10 first contents");
        chk(corr_total == 10, "R10 first", corr_total, 10);
        wr(0, 32'h0E_0E_00_01);
        scan(0, 4, 1'b0, "R10 rewritten");
        chk(corr_total == 29 && max_flips == 14, "R10 rewrite seen", corr_total, 29);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) mirror[k] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_bank();
        t_fill();
        scan(0, 4, 1'b0, "R1 aligned range");
        scan(1, 3, 1'b0, "R1 R3 crossing word");
        t_lanes();
        t_uncorr();
        scan(3, 16, 1'b0, "R1 full 16-step page");
        scan(15, 1, 1'b0, "R1 single step");
        scan(7, 0, 1'b0, "R2 zero steps");
        scan(1, 31, 1'b0, "R2 oversize steps");
        scan(12, 5, 1'b0, "R1 wrap past 63");
        scan(0, 8, 1'b1, "R9 start while busy");
        t_write();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule